// File: doc/BRIEF.md
# Phase-Gated Strided 3x3 Convolution Engine

This block computes a 3x3 two-dimensional convolution over an image that arrives as a stream, one signed pixel per accepted cycle, scanned left to right and top to bottom. It produces no padding. The stride is chosen at run time as 1, 2 or 4. The engine emits a result only at kernel positions whose top-left corner lies on the stride grid, so the output map is floor((W-3)/S)+1 columns by floor((H-3)/S)+1 rows. Results appear in raster order and carry a frame-end marker on the final one.

The engine treats the image as a set of interleaved sub-images selected by the low bits of the row and column counters. Two line stores hold earlier rows. Each row is written into only one of them, chosen by row parity. At stride 4, rows and columns that no kernel footprint touches are not stored at all. The nine window registers are updated only on rows that can complete a footprint, and only for columns that belong to a footprint. Everywhere else their enables stay low. Each result is the dot product of the updated window with the nine weights, and it is registered one cycle after the completing pixel.

Top module: `strided_conv3x3`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, out_valid and out_last are low.
- R2: With stride_code 0 (stride 1), the pixel at row y, column x (both at least 2) produces a result equal to the sum over ky,kx in 0..2 of pixel(y-2+ky, x-2+kx) times weight k=3*ky+kx. Weight k sits at weights bits [8k+7:8k]. There are (W-2)*(H-2) results per frame, in raster order.
- R3: With stride_code 1 (stride 2), results are produced only at pixels where y-2 and x-2 are both non-negative multiples of 2. There are (floor((W-3)/2)+1)*(floor((H-3)/2)+1) results per frame.
- R4: With stride_code 2 (stride 4), results are produced only at pixels where y-2 and x-2 are both non-negative multiples of 4. The count follows the same formula with divisor 4.
- R5: stride_code 3 behaves exactly as stride 1.
- R6: out_valid is high for exactly one cycle, immediately after the clock edge that accepts a footprint-completing pixel, and at no other time.
- R7: out_last is high together with the final result of a frame and with no other result.
- R8: Cycles with in_valid low change nothing. After the last pixel of a frame, the next accepted pixel starts a new frame, and new size, stride and weights set between frames take effect.
- R9: Results are exact 20-bit signed values, including all-extreme operands (-128 pixels with -128 weights gives 147456).
- R10: At stride 4, pixels in rows or columns congruent to 3 mod 4 have no effect on any result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A pixel is presented this cycle |
| in_pixel | input | 8 | Signed pixel value |
| img_w | input | 7 | Image width in pixels (3..MAX_W) |
| img_h | input | 7 | Image height in pixels (3..MAX_H) |
| stride_code | input | 2 | 0: stride 1, 1: stride 2, 2: stride 4, 3: stride 1 |
| weights | input | 72 | Nine signed 8-bit weights, weight k at bits [8k+7:8k] |
| out_valid | output | 1 | out_data holds a new result |
| out_data | output | 20 | Signed convolution result |
| out_last | output | 1 | Marks the final result of the frame |

## Verification
The in-RTL properties assume three things about the inputs: width and height lie between 3 and the configured maxima, and the size, stride and weights do not change while a frame is partly received. The bounds property on the position counters depends on this. The bench builds every frame inside those limits and changes the configuration only after the last pixel of a frame has been accepted. It inserts idle cycles inside frames and runs frames back to back, so the idle-hold and frame-wrap properties see both situations.

// File: rtl/sconv_pkg.sv
// Shared widths, types and stride decoding for the strided convolution engine.
// Assumes a fixed 3x3 kernel; only power-of-two strides up to 4 are encoded.
package sconv_pkg;
    localparam int PIX_W = 8;
    localparam int WGT_W = 8;
    localparam int ACC_W = 20;
    localparam int KSZ   = 3;
    localparam int TAPS  = KSZ * KSZ;
    localparam int PRD_W = PIX_W + WGT_W;

    typedef logic signed [PIX_W-1:0] pix_t;
    typedef logic signed [WGT_W-1:0] wgt_t;
    typedef logic signed [ACC_W-1:0] acc_t;

    // Map the stride code to a shift amount (log2 of the stride).
    function automatic logic [1:0] stride_shift(input logic [1:0] code);
        case (code)
            2'd1:    return 2'd1;
            2'd2:    return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

    // True when (v - 2) is a multiple of the stride, decided from the low two bits.
    function automatic logic phase_hit(input logic [1:0] sh, input logic [1:0] low);
        case (sh)
            2'd1:    return !low[0];
            2'd2:    return low == 2'b10;
            default: return 1'b1;
        endcase
    endfunction
endpackage

// File: rtl/phase_ctrl.sv
// Position counters and phase decoding. Produces the line-store and window
// enables, the emit strobe and the frame-end flag.
// Assumes img_w/img_h in 3..MAX and a configuration held stable within a frame.
module phase_ctrl
    import sconv_pkg::*;
#(
    parameter int MAX_W = 64,
    parameter int MAX_H = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [$clog2(MAX_W+1)-1:0] img_w,
    input  logic [$clog2(MAX_H+1)-1:0] img_h,
    input  logic [1:0]                 stride_code,
    output logic [$clog2(MAX_W)-1:0]   col,
    output logic                       lb_sel,
    output logic                       lb_we,
    output logic                       win_en,
    output logic                       emit,
    output logic                       emit_last
);
    localparam int CW = $clog2(MAX_W);
    localparam int RW = $clog2(MAX_H);
    localparam int DW = $clog2(MAX_W+1);
    localparam int HW = $clog2(MAX_H+1);

    logic [RW-1:0] row;
    logic [DW-1:0] col_ext;
    logic [HW-1:0] row_ext;
    logic [1:0]    sh;
    logic          col_end, row_end;
    logic          store_row, col_used, out_row, out_col;
    logic [DW-1:0] last_c;
    logic [HW-1:0] last_r;

    // Decode the current position against the stride grid.
    always_comb begin
        sh        = stride_shift(stride_code);
        col_ext   = DW'(col);
        row_ext   = HW'(row);
        col_end   = col_ext == img_w - DW'(1);
        row_end   = row_ext == img_h - HW'(1);
        store_row = (sh == 2'd2) ? !row[1] : 1'b1;
        col_used  = (sh == 2'd2) ? (col[1:0] != 2'b11) : 1'b1;
        out_row   = (row_ext >= HW'(KSZ-1)) && phase_hit(sh, row[1:0]);
        out_col   = (col_ext >= DW'(KSZ-1)) && phase_hit(sh, col[1:0]);
        last_c    = (((img_w - DW'(KSZ)) >> sh) << sh) + DW'(KSZ-1);
        last_r    = (((img_h - HW'(KSZ)) >> sh) << sh) + HW'(KSZ-1);
        lb_sel    = row[0];
        lb_we     = in_valid && store_row && col_used;
        win_en    = in_valid && out_row && col_used;
        emit      = win_en && out_col;
        emit_last = emit && (col_ext == last_c) && (row_ext == last_r);
    end

    // Advance the raster position on each accepted pixel, wrapping at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col <= '0;
            row <= '0;
        end else if (in_valid) begin
            if (col_end) begin
                col <= '0;
                row <= row_end ? '0 : row + RW'(1);
            end else begin
                col <= col + CW'(1);
            end
        end
    end

    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(col) && $stable(row));
    assert_frame_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && col_end && row_end) |=> (col == '0) && (row == '0));
    assert_in_bounds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (col_ext < img_w) && (row_ext < img_h));
endmodule

// File: rtl/line_store.sv
// Two row stores indexed by column. A write goes to the store picked by
// lb_sel; reads return the older row (same parity) and the newer row.
// Data is not reset: no entry is read before the frame has written it.
module line_store
    import sconv_pkg::*;
#(
    parameter int MAX_W = 64
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic                     sel,
    input  logic [$clog2(MAX_W)-1:0] addr,
    input  pix_t                     din,
    output pix_t                     top,
    output pix_t                     mid
);
    localparam int CW = $clog2(MAX_W);

    pix_t even_row [MAX_W];
    pix_t odd_row  [MAX_W];

    for (genvar i = 0; i < MAX_W; i++) begin : g_entry
        // Write one entry of the even-parity store when addressed.
        always_ff @(posedge clk) begin
            if (we && !sel && addr == CW'(i)) even_row[i] <= din;
        end
        // Write one entry of the odd-parity store when addressed.
        always_ff @(posedge clk) begin
            if (we && sel && addr == CW'(i)) odd_row[i] <= din;
        end
    end

    // Older row shares parity with the current row; newer row is the other store.
    always_comb begin
        top = sel ? odd_row[addr]  : even_row[addr];
        mid = sel ? even_row[addr] : odd_row[addr];
    end
endmodule

// File: rtl/window_mac.sv
// Nine-register window with column shift under enable, and a dot product
// with the weights taken over the post-shift window; result registered.
// Assumes emit is only raised together with win_en.
module window_mac
    import sconv_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   win_en,
    input  logic                   emit,
    input  logic                   emit_last,
    input  pix_t                   top,
    input  pix_t                   mid,
    input  pix_t                   pix,
    input  logic [TAPS*WGT_W-1:0]  weights,
    output logic                   out_valid,
    output acc_t                   out_data,
    output logic                   out_last
);
    pix_t win [KSZ][KSZ];
    pix_t nxt [KSZ][KSZ];
    wgt_t wt  [TAPS];
    acc_t sum;

    // Slice the packed weight bus into signed taps.
    always_comb begin
        for (int k = 0; k < TAPS; k++) wt[k] = $signed(weights[k*WGT_W +: WGT_W]);
    end

    // Post-shift window: older columns move left, the new column enters on the right.
    always_comb begin
        for (int r = 0; r < KSZ; r++) begin
            for (int c = 0; c < KSZ-1; c++) nxt[r][c] = win[r][c+1];
        end
        nxt[0][KSZ-1] = top;
        nxt[1][KSZ-1] = mid;
        nxt[2][KSZ-1] = pix;
    end

    // Dot product of the post-shift window with the weights.
    always_comb begin
        logic signed [PRD_W-1:0] prod;
        sum = '0;
        for (int r = 0; r < KSZ; r++) begin
            for (int c = 0; c < KSZ; c++) begin
                prod = PRD_W'(nxt[r][c]) * PRD_W'(wt[r*KSZ+c]);
                sum  = sum + ACC_W'(prod);
            end
        end
    end

    // Window registers change only when their enable is raised.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < KSZ; r++)
                for (int c = 0; c < KSZ; c++) win[r][c] <= '0;
        end else if (win_en) begin
            win <= nxt;
        end
    end

    // Register the result stream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= emit;
            out_last  <= emit_last;
            if (emit) out_data <= sum;
        end
    end

    assert_last_with_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);
    assert_emit_needs_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
        emit |-> win_en);
    assert_valid_after_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(win_en));
endmodule

// File: rtl/strided_conv3x3.sv
// Top level: streaming 3x3 convolution with run-time stride 1/2/4.
// Assumes the configuration inputs change only between frames.
module strided_conv3x3
    import sconv_pkg::*;
#(
    parameter int MAX_W = 64,
    parameter int MAX_H = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic signed [7:0]          in_pixel,
    input  logic [$clog2(MAX_W+1)-1:0] img_w,
    input  logic [$clog2(MAX_H+1)-1:0] img_h,
    input  logic [1:0]                 stride_code,
    input  logic [71:0]                weights,
    output logic                       out_valid,
    output logic signed [19:0]         out_data,
    output logic                       out_last
);
    localparam int CW = $clog2(MAX_W);

    logic [CW-1:0] col;
    logic          lb_sel, lb_we, win_en, emit, emit_last;
    pix_t          top, mid;

    phase_ctrl #(.MAX_W(MAX_W), .MAX_H(MAX_H)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .img_w(img_w), .img_h(img_h), .stride_code(stride_code),
        .col(col), .lb_sel(lb_sel), .lb_we(lb_we), .win_en(win_en),
        .emit(emit), .emit_last(emit_last)
    );

    line_store #(.MAX_W(MAX_W)) u_lines (
        .clk(clk), .we(lb_we), .sel(lb_sel), .addr(col),
        .din(in_pixel), .top(top), .mid(mid)
    );

    window_mac u_mac (
        .clk(clk), .rst_n(rst_n), .win_en(win_en), .emit(emit),
        .emit_last(emit_last), .top(top), .mid(mid), .pix(in_pixel),
        .weights(weights), .out_valid(out_valid), .out_data(out_data),
        .out_last(out_last)
    );

    assert_out_follows_pixel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));
endmodule

// File: tb/tb_strided_conv3x3.sv
module tb_strided_conv3x3;
    localparam int MAX_W = 64;
    localparam int MAX_H = 64;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [7:0]  in_pixel = '0;
    logic [6:0]         img_w = 7'd3;
    logic [6:0]         img_h = 7'd3;
    logic [1:0]         stride_code = 2'd0;
    logic [71:0]        weights = '0;
    logic               out_valid;
    logic signed [19:0] out_data;
    logic               out_last;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int wt [9];
    logic signed [7:0] img [0:MAX_H-1][0:MAX_W-1];
    int lcg = 7;

    strided_conv3x3 #(.MAX_W(MAX_W), .MAX_H(MAX_H)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pixel(in_pixel),
        .img_w(img_w), .img_h(img_h), .stride_code(stride_code),
        .weights(weights), .out_valid(out_valid), .out_data(out_data),
        .out_last(out_last)
    );

    always #10 clk = ~clk;

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic signed [7:0] next_rand();
        lcg = lcg * 1103515245 + 12345;
        return lcg[23:16];
    endfunction

    task automatic fill_random(int w, int h);
        for (int y = 0; y < h; y++)
            for (int x = 0; x < w; x++) img[y][x] = next_rand();
    endtask

    task automatic fill_const(int w, int h, int v);
        for (int y = 0; y < h; y++)
            for (int x = 0; x < w; x++) img[y][x] = 8'(v);
    endtask

    task automatic set_weights_random();
        for (int k = 0; k < 9; k++) wt[k] = int'(next_rand());
    endtask

    function automatic int ref_dot(int y, int x);
        int s = 0;
        for (int ky = 0; ky < 3; ky++)
            for (int kx = 0; kx < 3; kx++)
                s += int'(img[y-2+ky][x-2+kx]) * wt[3*ky+kx];
        return s;
    endfunction

    // Drive one frame, checking every cycle's output against the reference.
    task automatic run_frame(string req, int w, int h, int code, int gap_every);
        int s = (code == 1) ? 2 : (code == 2) ? 4 : 1;
        int lastr = ((h-3)/s)*s + 2;
        int lastc = ((w-3)/s)*s + 2;
        int exp_cnt = ((w-3)/s + 1) * ((h-3)/s + 1);
        int outs = 0;
        img_w = 7'(w);
        img_h = 7'(h);
        stride_code = 2'(code);
        for (int k = 0; k < 9; k++) weights[k*8 +: 8] = wt[k][7:0];
        for (int y = 0; y < h; y++) begin
            for (int x = 0; x < w; x++) begin
                bit exp_emit;
                if (gap_every > 0 && ((y*w + x) % gap_every) == gap_every - 1) begin
                    in_valid = 1'b0;
                    @(posedge clk); @(negedge clk);
                    check("R8", "idle cycle out_valid", int'(out_valid), 0);
                end
                in_valid = 1'b1;
                in_pixel = img[y][x];
                @(posedge clk); @(negedge clk);
                in_valid = 1'b0;
                exp_emit = (y >= 2) && (x >= 2) && ((y-2) % s == 0) && ((x-2) % s == 0);
                check("R6", $sformatf("%s valid at (%0d,%0d)", req, y, x),
                      int'(out_valid), int'(exp_emit));
                if (exp_emit && out_valid) begin
                    outs++;
                    check(req, $sformatf("data at (%0d,%0d)", y, x), int'(out_data), ref_dot(y, x));
                    check("R7", $sformatf("last at (%0d,%0d)", y, x), int'(out_last),
                          int'(y == lastr && x == lastc));
                end
            end
        end
        check(req, "result count", outs, exp_cnt);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        in_valid = 1'b1;
        in_pixel = 8'sd5;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R1", "out_valid in reset", int'(out_valid), 0);
        check("R1", "out_last in reset", int'(out_last), 0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R1", "out_valid after release", int'(out_valid), 0);
    endtask

    task automatic test_stride1();
        set_weights_random();
        fill_random(8, 6);
        run_frame("R2", 8, 6, 0, 0);
    endtask

    task automatic test_stride2_gaps();
        set_weights_random();
        fill_random(9, 7);
        run_frame("R3", 9, 7, 1, 5);
    endtask

    task automatic test_stride4_skip();
        set_weights_random();
        fill_random(11, 10);
        run_frame("R4", 11, 10, 2, 0);
        // R10: overwrite pixels no footprint uses, results must not change
        for (int y = 0; y < 10; y++)
            for (int x = 0; x < 11; x++)
                if ((y % 4) == 3 || (x % 4) == 3) img[y][x] = 8'sd127;
        run_frame("R10", 11, 10, 2, 0);
    endtask

    task automatic test_code3();
        set_weights_random();
        fill_random(6, 5);
        run_frame("R5", 6, 5, 3, 0);
    endtask

    task automatic test_extremes();
        for (int k = 0; k < 9; k++) wt[k] = -128;
        fill_const(3, 3, -128);
        run_frame("R9", 3, 3, 1, 0);
        fill_const(3, 3, 127);
        run_frame("R9", 3, 3, 2, 0);
    endtask

    task automatic test_wide_row();
        set_weights_random();
        fill_random(64, 4);
        run_frame("R3", 64, 4, 1, 0);
    endtask

    task automatic test_back_to_back();
        set_weights_random();
        fill_random(7, 7);
        run_frame("R8", 7, 7, 2, 3);
        set_weights_random();
        fill_random(4, 4);
        run_frame("R8", 4, 4, 0, 0);
        @(posedge clk); @(negedge clk);
        check("R8", "idle after frame", int'(out_valid), 0);
    endtask

    initial begin
        test_reset();
        test_stride1();
        test_stride2_gaps();
        test_stride4_skip();
        test_code3();
        test_extremes();
        test_wide_row();
        test_back_to_back();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule